// File: doc/BRIEF.md
# I2C Byte Master

This block is a byte-at-a-time I2C bus master run by software through four 8-bit registers: control, status, data and own address. Software loads the data register and then writes the status register to launch a START. The block sends that byte as the address, then moves one byte per handshake, in either direction. After every acknowledge slot it sets a pending flag, raises an interrupt if one is enabled, and holds SCL low. The bus stays frozen until software writes the flag back to zero. A status write made while a byte is pending selects what happens next: a repeated START, a STOP, or another data byte. SCL and SDA are open-drain lines, modelled as output enables (1 pulls the line low). SDA is also read back through a synchronizer.

The bit engine is a state machine with six states. It leaves ST_IDLE for ST_START when a START is requested. ST_START goes to ST_BIT after four quarter phases. ST_BIT goes to ST_ACK after eight bits. ST_ACK goes to ST_HOLD after the acknowledge slot. When the pending flag is cleared, ST_HOLD goes to ST_START (repeated START), to ST_STOP, or back to ST_BIT for the next byte. ST_STOP returns to ST_IDLE. Every bit is four quarter phases long: two with SCL low, then two with SCL released. A two-stage divider produces the quarter-phase tick.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00. Both line enables are 0 and irq is 0.
- R2: The SCL period is P*(D+1) clocks. D is control[3:0]. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R3: A START is launched by writing the status register at offset 0x4 with bit 7 = 1 (master), bit 5 = 1 (start/stop) and bit 4 = 1 (enable). Bit 6 selects the mode: 1 = transmit, 0 = receive. The block produces a START condition, then sends the data register (offset 0xC) MSB first as the address byte. Status bit 5 reads 1 (busy) from the START until the STOP.
- R4: After each acknowledge slot, control bit 4 (pending) becomes 1 and SCL stays low for as long as it is 1. A control write with bit 4 = 0 clears it. A control write with bit 4 = 1 leaves it unchanged.
- R5: Status bit 0 holds the acknowledge sampled after the last transmitted byte: 1 = NACK, 0 = ACK.
- R6: In transmit mode (status bits 7:6 = 11), clearing pending sends the byte currently held in the data register.
- R7: In receive mode (status bits 7:6 = 10), once pending rises the data register holds the received byte. In the acknowledge slot the block drives ACK if control bit 7 is 1 and NACK if it is 0.
- R8: A status write with bits 7 and 4 set and bit 5 clear, made while busy, produces a STOP once pending is cleared. Busy then returns to 0 and both lines are released.
- R9: A START written while a byte is pending, followed by clearing pending, produces a repeated START with no STOP in between, followed by a new address byte.
- R10: A START write with status bit 4 = 0 starts nothing: no START condition, and busy stays 0.
- R11: irq is 1 exactly when pending is 1 and control bit 5 is 1.
- R12: The own-address register at offset 0x8 reads back the last value written to it and has no effect on the bus.
- R13: SDA changes while SCL is high only to form a START (falling) or a STOP (rising).
- R14: An access held on sel is accepted on one clock edge. ready is 1 for exactly the following cycle, and rdata is valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access request, held until ready |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 status, 0x8 own address, 0xC data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while ready is 1 |
| ready | output | 1 | One-cycle access completion |
| irq | output | 1 | Byte-complete interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
Register writes take effect on the accept edge, and read data appears in the following cycle, which is when ready is high. The bench therefore samples rdata and ready at the falling edge after the accept. Pending and busy arrive a whole number of SCL periods after a stimulus, so the bench never counts cycles for them. It polls the control or status register until the flag changes, with a poll limit. Line-level results (START and STOP counts, captured bytes, acknowledge bits, SCL period) are recorded by a slave model that reacts to line edges. The SCL period is measured between the final two SCL rises of a byte, where every quarter phase is complete, so P*(D+1) is exact there.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } eng_state_t;

    // register offsets (byte addresses)
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_OWN  = 4'h8;
    localparam logic [3:0] OFS_DATA = 4'hC;

    // control bit positions
    localparam int C_ACKEN = 7;
    localparam int C_PRE   = 6;
    localparam int C_IEN   = 5;
    localparam int C_PEND  = 4;

    // status bit positions
    localparam int S_MASTER = 7;
    localparam int S_TX     = 6;
    localparam int S_STRT   = 5;
    localparam int S_EN     = 4;
    localparam int S_NACK   = 0;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r[0] <= 1'b1;
        else        r[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r[i] <= 1'b1;
            else        r[i] <= r[i-1];
        end
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_hi,
    input  logic [DIV_W-1:0] div,
    output logic             qt
);
    localparam int Q_LO = PRE_LO / 4;
    localparam int Q_HI = PRE_HI / 4;
    localparam int CW   = (Q_HI > 1) ? $clog2(Q_HI) : 1;

    logic [CW-1:0]    c1;
    logic [CW-1:0]    lim;
    logic [DIV_W-1:0] c2;
    logic             t1;

    assign lim = pre_hi ? CW'(Q_HI - 1) : CW'(Q_LO - 1);
    assign t1  = (c1 >= lim);
    assign qt  = t1 && (c2 >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1 <= '0;
            c2 <= '0;
        end else begin
            c1 <= t1 ? '0 : c1 + 1'b1;
            if (t1) c2 <= (c2 >= div) ? '0 : c2 + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              ready,
    input  logic              busy,
    input  logic              take,
    input  logic              done,
    input  logic              rx_valid,
    input  logic [REG_W-1:0]  rx_byte,
    input  logic              nack_valid,
    input  logic              nack_val,
    output logic              ack_en,
    output logic              pre_hi,
    output logic              ien,
    output logic              pend,
    output logic [DIV_W-1:0]  div,
    output logic              mode_tx,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic [REG_W-1:0]  data_q
);
    logic [1:0]       mode;
    logic             txen;
    logic             nack;
    logic [REG_W-1:0] own_q;
    logic             acc, wr_en;
    logic [REG_W-1:0] rd_mux;

    assign acc     = sel && !ready;
    assign wr_en   = acc && wr;
    assign mode_tx = mode[0];

    always_comb begin
        rd_mux = '0;
        case (addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[C_ACKEN] = ack_en;
                rd_mux[C_PRE]   = pre_hi;
                rd_mux[C_IEN]   = ien;
                rd_mux[C_PEND]  = pend;
                rd_mux[DIV_W-1:0] = div;
            end
            ADDR_W'(OFS_STAT): begin
                rd_mux[S_MASTER:S_TX] = mode;
                rd_mux[S_STRT]        = busy;
                rd_mux[S_EN]          = txen;
                rd_mux[S_NACK]        = nack;
            end
            ADDR_W'(OFS_OWN):  rd_mux = own_q;
            ADDR_W'(OFS_DATA): rd_mux = data_q;
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready     <= 1'b0;
            rdata     <= '0;
            ack_en    <= 1'b0;
            pre_hi    <= 1'b0;
            ien       <= 1'b0;
            pend      <= 1'b0;
            div       <= '0;
            mode      <= 2'b00;
            txen      <= 1'b0;
            nack      <= 1'b0;
            own_q     <= '0;
            data_q    <= '0;
            start_cmd <= 1'b0;
            stop_cmd  <= 1'b0;
        end else begin
            ready <= acc;
            if (acc) rdata <= rd_mux;

            // control register
            if (wr_en && addr == ADDR_W'(OFS_CTRL)) begin
                ack_en <= wdata[C_ACKEN];
                pre_hi <= wdata[C_PRE];
                ien    <= wdata[C_IEN];
                div    <= wdata[DIV_W-1:0];
                if (!wdata[C_PEND]) pend <= 1'b0;
            end
            if (done) pend <= 1'b1;

            // command requests: engine take clears, a new write sets
            if (take) begin
                start_cmd <= 1'b0;
                stop_cmd  <= 1'b0;
            end
            if (wr_en && addr == ADDR_W'(OFS_STAT)) begin
                mode <= wdata[S_MASTER:S_TX];
                txen <= wdata[S_EN];
                if (wdata[S_MASTER] && wdata[S_EN]) begin
                    if (wdata[S_STRT]) begin
                        start_cmd <= 1'b1;
                        stop_cmd  <= 1'b0;
                    end else if (busy) begin
                        stop_cmd  <= 1'b1;
                        start_cmd <= 1'b0;
                    end
                end
            end

            if (nack_valid) nack <= nack_val;

            if (wr_en && addr == ADDR_W'(OFS_OWN)) own_q <= wdata;

            if (wr_en && addr == ADDR_W'(OFS_DATA)) data_q <= wdata;
            if (rx_valid) data_q <= rx_byte;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qt,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             pend,
    input  logic             mode_tx,
    input  logic             ack_en,
    input  logic [REG_W-1:0] data_in,
    input  logic             sda_s,
    output eng_state_t       state,
    output logic             busy,
    output logic             take,
    output logic             done,
    output logic             rx_valid,
    output logic [REG_W-1:0] rx_byte,
    output logic             nack_valid,
    output logic             nack_val,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic [1:0]       ph;
    logic [2:0]       bitn;
    logic [REG_W-1:0] shreg;
    logic             drv_lo;
    logic             rx;
    logic             first;
    logic             rep;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph     <= 2'd0;
            bitn   <= 3'd0;
            shreg  <= '0;
            drv_lo <= 1'b0;
            rx     <= 1'b0;
            first  <= 1'b0;
            rep    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_cmd) begin
                        state <= ST_START;
                        ph    <= 2'd0;
                        rep   <= 1'b0;
                    end
                end
                ST_START: begin
                    if (qt) begin
                        if (ph == 2'd3) begin
                            state  <= ST_BIT;
                            bitn   <= 3'd0;
                            shreg  <= data_in;
                            drv_lo <= 1'b1;
                            rx     <= 1'b0;
                            first  <= 1'b1;
                        end
                        ph <= ph + 2'd1;
                    end
                end
                ST_BIT: begin
                    if (qt) begin
                        ph <= ph + 2'd1;
                        if (ph == 2'd0) drv_lo <= rx ? 1'b0 : ~shreg[REG_W-1];
                        if (ph == 2'd2) shreg <= {shreg[REG_W-2:0], sda_s};
                        if (ph == 2'd3) begin
                            if (bitn == 3'd7) state <= ST_ACK;
                            bitn <= bitn + 3'd1;
                        end
                    end
                end
                ST_ACK: begin
                    if (qt) begin
                        ph <= ph + 2'd1;
                        if (ph == 2'd0) drv_lo <= rx && ack_en;
                        if (ph == 2'd3) begin
                            state <= ST_HOLD;
                            if (first) begin
                                rx    <= ~mode_tx;
                                first <= 1'b0;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (!pend) begin
                        ph <= 2'd0;
                        if (start_cmd) begin
                            state <= ST_START;
                            rep   <= 1'b1;
                        end else if (stop_cmd) begin
                            state <= ST_STOP;
                        end else begin
                            state <= ST_BIT;
                            bitn  <= 3'd0;
                            if (!rx) shreg <= data_in;
                        end
                    end
                end
                ST_STOP: begin
                    if (qt) begin
                        if (ph == 2'd3) begin
                            state  <= ST_IDLE;
                            drv_lo <= 1'b0;
                        end
                        ph <= ph + 2'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign rx_byte = shreg;

    // outputs
    always_comb begin
        scl_oe     = 1'b0;
        sda_oe     = 1'b0;
        take       = 1'b0;
        done       = 1'b0;
        rx_valid   = 1'b0;
        nack_valid = 1'b0;
        nack_val   = sda_s;
        unique case (state)
            ST_IDLE: begin
                take = start_cmd;
            end
            ST_START: begin
                scl_oe = (ph == 2'd0) ? rep : 1'b0;
                sda_oe = ph[1];
            end
            ST_BIT: begin
                scl_oe = ~ph[1];
                sda_oe = drv_lo;
            end
            ST_ACK: begin
                scl_oe     = ~ph[1];
                sda_oe     = drv_lo;
                nack_valid = qt && (ph == 2'd2) && !rx;
                done       = qt && (ph == 2'd3);
                rx_valid   = qt && (ph == 2'd3) && rx;
            end
            ST_HOLD: begin
                scl_oe = 1'b1;
                sda_oe = drv_lo;
                take   = !pend && (start_cmd || stop_cmd);
            end
            ST_STOP: begin
                scl_oe = ~ph[1];
                sda_oe = (ph != 2'd3);
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DIV_W       = 4,
    parameter int PRE_LO      = 16,
    parameter int PRE_HI      = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic             qt, sda_s;
    logic             ack_en, pre_hi, ien, pend, mode_tx;
    logic [DIV_W-1:0] div;
    logic             start_cmd, stop_cmd;
    logic [REG_W-1:0] data_q, rx_byte;
    logic             busy, take, done, rx_valid, nack_valid, nack_val;
    eng_state_t       eng_state;
    logic             in_start, in_stop;

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2cm_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .pre_hi(pre_hi), .div(div), .qt(qt)
    );

    i2cm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .busy(busy),
        .take(take), .done(done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .nack_valid(nack_valid), .nack_val(nack_val), .ack_en(ack_en),
        .pre_hi(pre_hi), .ien(ien), .pend(pend), .div(div),
        .mode_tx(mode_tx), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .data_q(data_q)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .qt(qt), .start_cmd(start_cmd),
        .stop_cmd(stop_cmd), .pend(pend), .mode_tx(mode_tx),
        .ack_en(ack_en), .data_in(data_q), .sda_s(sda_s),
        .state(eng_state), .busy(busy), .take(take), .done(done),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .nack_valid(nack_valid),
        .nack_val(nack_val), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    assign irq      = pend && ien;
    assign in_start = (eng_state == ST_START);
    assign in_stop  = (eng_state == ST_STOP);
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq,
    input logic ready,
    input logic pend,
    input logic busy,
    input logic in_start,
    input logic in_stop
);
    assert_scl_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> scl_oe);

    assert_irq_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    assert_sda_fall_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> in_start);

    assert_sda_rise_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> in_stop);

    assert_ready_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
endmodule

bind i2c_byte_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .ready(ready), .pend(pend), .busy(busy), .in_start(in_start),
    .in_stop(in_stop)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_OWN = 4'h8, A_DATA = 4'hC;
    localparam logic [6:0] SLV = 7'h52;

    logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic ready, irq, scl_oe, sda_oe;
    logic s_low = 1'b0;
    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || s_low);

    int checks = 0, errors = 0, cyc = 0;

    i2c_byte_master uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] rd_val(input int k);
        return 8'hA7 ^ 8'(k * 29);
    endfunction

    // ---------------- slave model ----------------
    int nstart = 0, nstop = 0, nwr = 0, rises = 0, per = 0, last_rise = 0;
    logic [7:0] sh = '0, abyte = '0;
    logic [7:0] wlog [8];
    logic matched = 1'b0, is_read = 1'b0, released = 1'b0, mack = 1'b0;

    always @(negedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        nstart++; rises = 0; matched = 0; is_read = 0; released = 0; s_low = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1 && rst_n) begin
        nstop++; s_low = 0;
    end
    always @(posedge scl_line) if (rst_n) begin
        per = cyc - last_rise; last_rise = cyc;
        if (rises % 9 < 8) sh = {sh[6:0], sda_line};
        else if (rises / 9 == 0) begin
            abyte = sh; matched = (sh[7:1] == SLV); is_read = sh[0];
        end else if (is_read) begin
            mack = sda_line; if (sda_line) released = 1;
        end else if (matched && nwr < 8) begin
            wlog[nwr] = sh; nwr++;
        end
        rises++;
    end
    always @(negedge scl_line) if (rst_n) begin
        int pos, byt;
        pos = rises % 9; byt = rises / 9;
        s_low = 0;
        if (rises > 0) begin
            if (pos == 8 && byt == 0) s_low = (sh[7:1] == SLV);
            else if (pos == 8) s_low = matched && !is_read;
            else if (byt > 0 && matched && is_read && !released)
                s_low = !rd_val(byt - 1)[7 - pos];
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R-watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(negedge clk); d = rdata; sel = 0;
    endtask

    task automatic wait_pend(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(A_CTRL, v);
            if (v[4]) return;
        end
        chk({req, " pending timeout"}, 0, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(A_STAT, v);
            if (!v[5]) return;
        end
        chk({req, " idle timeout"}, 0, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [7:0] v;
        bus_rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        bus_rd(A_STAT, v); chk("R1 stat", v, 0);
        bus_rd(A_DATA, v); chk("R1 data", v, 0);
        chk("R1 lines", {scl_oe, sda_oe, irq}, 0);
        @(negedge clk); sel = 1; addr = A_CTRL;
        @(negedge clk); chk("R14 ready high", ready, 1); sel = 0;
        @(negedge clk); chk("R14 ready one cycle", ready, 0);
    endtask

    task automatic t_own;
        logic [7:0] v;
        bus_wr(A_OWN, 8'h3C);
        bus_rd(A_OWN, v); chk("R12 own readback", v, 8'h3C);
        repeat (40) @(negedge clk);
        bus_rd(A_STAT, v); chk("R12 no bus activity", {v[5], scl_oe, sda_oe}, 0);
    endtask

    task automatic t_noen;
        logic [7:0] v;
        int n0;
        n0 = nstart;
        bus_wr(A_STAT, 8'hE0);
        repeat (200) @(negedge clk);
        chk("R10 no start", nstart, n0);
        bus_rd(A_STAT, v); chk("R10 not busy", v[5], 0);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int n0, s0;
        nwr = 0; n0 = nstart; s0 = nstop;
        bus_wr(A_CTRL, 8'hA0);
        bus_wr(A_DATA, {SLV, 1'b0});
        bus_wr(A_STAT, 8'hF0);
        wait_pend("R3");
        chk("R3 start seen", nstart, n0 + 1);
        chk("R3 address byte", abyte, {SLV, 1'b0});
        bus_rd(A_STAT, v);
        chk("R3 busy", v[5], 1);
        chk("R5 ack", v[0], 0);
        chk("R11 irq on", irq, 1);
        repeat (100) @(negedge clk);
        chk("R4 scl held", scl_oe, 1);
        bus_wr(A_CTRL, 8'h90);
        chk("R11 irq masked", irq, 0);
        bus_rd(A_CTRL, v); chk("R4 write 1 keeps pending", v[4], 1);
        bus_wr(A_DATA, 8'hC3); bus_wr(A_CTRL, 8'hA0);
        wait_pend("R6");
        bus_wr(A_DATA, 8'h18); bus_wr(A_CTRL, 8'hA0);
        wait_pend("R6");
        chk("R6 byte count", nwr, 2);
        chk("R6 byte0", wlog[0], 8'hC3);
        chk("R6 byte1", wlog[1], 8'h18);
        bus_wr(A_STAT, 8'hD0); bus_wr(A_CTRL, 8'hA0);
        wait_idle("R8");
        chk("R8 stop seen", nstop, s0 + 1);
        chk("R8 lines released", {scl_oe, sda_oe}, 0);
        chk("R13 no stray start", nstart, n0 + 1);
    endtask

    task automatic t_nack;
        logic [7:0] v;
        bus_wr(A_CTRL, 8'hA0);
        bus_wr(A_DATA, {7'h11, 1'b0});
        bus_wr(A_STAT, 8'hF0);
        wait_pend("R5");
        bus_rd(A_STAT, v); chk("R5 nack", v[0], 1);
        bus_wr(A_STAT, 8'hD0); bus_wr(A_CTRL, 8'hA0);
        wait_idle("R8");
    endtask

    task automatic t_read;
        logic [7:0] v;
        int s0;
        s0 = nstop;
        bus_wr(A_CTRL, 8'hA0);
        bus_wr(A_DATA, {SLV, 1'b1});
        bus_wr(A_STAT, 8'hB0);
        wait_pend("R7");
        bus_wr(A_CTRL, 8'hA0);
        wait_pend("R7");
        bus_rd(A_DATA, v); chk("R7 rx byte0", v, rd_val(0));
        chk("R7 master ack", mack, 0);
        bus_wr(A_CTRL, 8'h20);
        wait_pend("R7");
        bus_rd(A_DATA, v); chk("R7 rx byte1", v, rd_val(1));
        chk("R7 master nack", mack, 1);
        bus_wr(A_STAT, 8'h90); bus_wr(A_CTRL, 8'h20);
        wait_idle("R8");
        chk("R8 stop after read", nstop, s0 + 1);
    endtask

    task automatic t_rstart;
        logic [7:0] v;
        int n0, s0;
        bus_wr(A_CTRL, 8'hA0);
        bus_wr(A_DATA, {SLV, 1'b0});
        bus_wr(A_STAT, 8'hF0);
        wait_pend("R9");
        n0 = nstart; s0 = nstop;
        bus_wr(A_DATA, {SLV, 1'b1});
        bus_wr(A_STAT, 8'hB0);
        bus_wr(A_CTRL, 8'h20);
        wait_pend("R9");
        chk("R9 repeated start", nstart, n0 + 1);
        chk("R9 no stop between", nstop, s0);
        chk("R9 new address", abyte, {SLV, 1'b1});
        bus_wr(A_CTRL, 8'h20);
        wait_pend("R9");
        bus_rd(A_DATA, v); chk("R9 read after restart", v, rd_val(0));
        bus_wr(A_STAT, 8'h90); bus_wr(A_CTRL, 8'h20);
        wait_idle("R9");
    endtask

    task automatic t_div;
        bus_wr(A_CTRL, 8'hA2);
        bus_wr(A_DATA, {SLV, 1'b0});
        bus_wr(A_STAT, 8'hF0);
        wait_pend("R2");
        chk("R2 period P16 D2", per, 48);
        bus_wr(A_STAT, 8'hD0); bus_wr(A_CTRL, 8'hA2);
        wait_idle("R2");
        bus_wr(A_CTRL, 8'hE0);
        bus_wr(A_STAT, 8'hF0);
        wait_pend("R2");
        chk("R2 period P512 D0", per, 512);
        bus_wr(A_STAT, 8'hD0); bus_wr(A_CTRL, 8'hE0);
        wait_idle("R2");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nstart = 0; nstop = 0;
        t_reset;
        t_own;
        t_noen;
        t_write;
        t_nack;
        t_read;
        t_rstart;
        t_div;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule